// File: doc/BRIEF.md
# Carry-Save CORDIC Vector Rotator

This block turns a two-dimensional vector (X, Y) through a signed angle Z with a sequence of radix-2 circular micro-rotations. Its usual job is producing cosine and sine: X is loaded with the reciprocal of the fixed CORDIC gain, Y with zero, and the two outputs are then the cosine and the sine of Z. Any other vector inside the allowed range is rotated as well, and the result carries that same constant gain.

The rotation direction for every micro-rotation is settled in the cycle the operand is accepted. A combinational digit generator works only from the input angle and produces the whole set of +1/-1 directions at once. The X/Y recurrence then runs in carry-save form. Each step is a pair of 3:2 compressor layers, so no step waits on a carry chain and nothing in the loop ever examines a sign. One ordinary adder per output turns the redundant result back into two's complement at the end.

Both data interfaces are valid/ready streams. An operand transfers on a rising edge where `in_valid` and `in_ready` are both high. A result transfers on an edge where `out_valid` and `out_ready` are both high. The unit holds one operation at a time. `in_ready` stays low from acceptance until the result has been taken, and a stalled result stays frozen on the output pins.

Top module: `rcordic_rot`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An operand is taken on a rising edge with `in_valid` and `in_ready` high. From the next cycle `in_ready` is 0 until the result is handed over.
- R3: With STEPS = W+2 micro-rotations, `out_valid` first goes high right after the (W+3)-th rising edge following the accepting edge.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_x` and `out_y` do not change. After the edge that transfers the result, `out_valid` is 0 and `in_ready` is 1.
- R5: X, Y, Z and both outputs are signed fixed point with W-2 fraction bits. Z is in radians within [-pi/2, pi/2]. With X = round(2^(W-2)/K) and Y = 0, the outputs match K·X·cos Z and K·X·sin Z within 2 LSB.
- R6: For |X|, |Y| ≤ 0.75, `out_x` is within 2 LSB of K(X cos Z − Y sin Z) and `out_y` is within 2 LSB of K(X sin Z + Y cos Z).
- R7: The gain K is the product of sqrt(1+2^(−2s)) over the shift schedule s = 0,1,…,W. Shift REPEAT_AT appears exactly twice in that schedule, once at step REPEAT_AT and once at step REPEAT_AT+1. K does not depend on the angle, so the output magnitude is K times the input magnitude for every Z.
- R8: Every direction is +1 or −1, never zero. The sequence is chosen greedily from the angle alone, so for an in-range Z the leftover angle never exceeds one last-step arctangent. At Z = 0 and at Z = ±pi/2 the outputs obey R5/R6 with no extra steps.
- R9: `in_valid` asserted while `in_ready` is 0 has no effect. The result delivered is that of the operand accepted earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle and able to take an operand |
| in_x | input | W | X component, signed, W-2 fraction bits |
| in_y | input | W | Y component, signed, W-2 fraction bits |
| in_z | input | W | Rotation angle in radians, signed, W-2 fraction bits |
| out_valid | output | 1 | Rotated vector available |
| out_ready | input | 1 | Consumer takes the result |
| out_x | output | W | Rotated X, signed, W-2 fraction bits |
| out_y | output | W | Rotated Y, signed, W-2 fraction bits |

## Verification
The property on the angle residual holds only for angles within [-pi/2, pi/2]. The overflow property on the final conversion holds only when the scaled input magnitude leaves headroom below 2.0. The bench keeps every angle it applies between ±round(pi/2·2^(W−2)) and every vector component within ±0.75, or at the 1/K preload for the sine/cosine sweep. The back-pressure properties assume the consumer may stall freely, so the bench varies the stall length and also drives junk operands while the unit is busy.

// File: rtl/rcordic_pkg.sv
package rcordic_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROT,
    ST_FIN,
    ST_HOLD
  } rot_state_e;

  // Shift amount used by micro-rotation number pos; index rep occurs twice.
  function automatic int step_shift(input int pos, input int rep);
    return (pos > rep) ? pos - 1 : pos;
  endfunction

  // arctan(2^-sh) in fixed point with frac fraction bits, rounded.
  function automatic longint angle_word(input int sh, input int frac);
    real a;
    a = $atan(1.0 / (2.0 ** sh));
    return longint'(a * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/rcordic_dirgen.sv
module rcordic_dirgen
  import rcordic_pkg::*;
#(
  parameter int W      = 16,
  parameter int ZGUARD = 8,
  parameter int STEPS  = W + 2,
  parameter int REP    = 3,
  localparam int ZW    = W + ZGUARD,
  localparam int ZF    = W - 2 + ZGUARD
) (
  input  logic signed [W-1:0]  angle,
  output logic [STEPS-1:0]     dir,
  output logic signed [ZW-1:0] resid
);

  logic signed [ZW-1:0] atab [STEPS];

  for (genvar p = 0; p < STEPS; p++) begin : g_tab
    localparam logic signed [ZW-1:0] AW = ZW'(angle_word(step_shift(p, REP), ZF));
    assign atab[p] = AW;
  end

  // Greedy non-restoring decomposition of the angle, all steps in one pass.
  logic signed [ZW-1:0] zacc;
  always_comb begin
    zacc = {angle, {ZGUARD{1'b0}}};
    for (int p = 0; p < STEPS; p++) begin
      dir[p] = ~zacc[ZW-1];
      if (dir[p]) zacc = zacc - atab[p];
      else        zacc = zacc + atab[p];
    end
    resid = zacc;
  end

endmodule

// File: rtl/rcordic_csa_step.sv
module rcordic_csa_step #(
  parameter int M   = 26,
  parameter int SHW = 5
) (
  input  logic [M-1:0]   acc_s,
  input  logic [M-1:0]   acc_c,
  input  logic [M-1:0]   op_s,
  input  logic [M-1:0]   op_c,
  input  logic [SHW-1:0] sh,
  input  logic           sub,
  output logic [M-1:0]   res_s,
  output logic [M-1:0]   res_c
);

  // Remove a hidden 2^M wrap between the two vectors so each can be
  // shifted arithmetically on its own (value is kept below 2^(M-2)).
  logic signed [M-1:0] fs, fc;
  always_comb begin
    fs = op_s;
    fc = op_c;
    if (op_s[M-1:M-2] == 2'b01 && op_c[M-1:M-2] == 2'b01) begin
      fs[M-1] = 1'b1;
      fc[M-1] = 1'b1;
    end else if (op_s[M-1:M-2] == 2'b10 && op_c[M-1:M-2] == 2'b10) begin
      fs[M-1] = 1'b0;
      fc[M-1] = 1'b0;
    end
  end

  logic signed [M-1:0] ts, tc;
  logic [M-1:0] ps, pc;
  assign ts = fs >>> sh;
  assign tc = fc >>> sh;
  assign ps = sub ? ~ts : ts;
  assign pc = sub ? ~tc : tc;

  // Two 3:2 layers; the freed carry LSBs carry the +2 of the negation.
  logic [M-1:0] s1;
  logic [M-2:0] maj1, maj2;
  logic [M-1:0] k1;
  assign s1   = acc_s ^ acc_c ^ ps;
  assign maj1 = (acc_s[M-2:0] & acc_c[M-2:0]) | (acc_s[M-2:0] & ps[M-2:0]) |
                (acc_c[M-2:0] & ps[M-2:0]);
  assign k1   = {maj1, sub};
  assign res_s = s1 ^ k1 ^ pc;
  assign maj2 = (s1[M-2:0] & k1[M-2:0]) | (s1[M-2:0] & pc[M-2:0]) |
                (k1[M-2:0] & pc[M-2:0]);
  assign res_c = {maj2, sub};

endmodule

// File: rtl/rcordic_resolve.sv
module rcordic_resolve #(
  parameter int M = 26,
  parameter int W = 16,
  parameter int G = 8
) (
  input  logic [M-1:0]        sum_v,
  input  logic [M-1:0]        car_v,
  output logic signed [W-1:0] value,
  output logic                spill
);

  logic [M-1:0] total;
  logic         unused_round;

  assign total = sum_v + car_v + (M'(1) << (G - 1));
  assign value = total[G+W-1:G];
  assign spill = !((&total[M-1:G+W-1]) || !(|total[M-1:G+W-1]));
  assign unused_round = ^total[G-1:0];

endmodule

// File: rtl/rcordic_rot.sv
module rcordic_rot
  import rcordic_pkg::*;
#(
  parameter int W         = 16,
  parameter int GUARD     = 8,
  parameter int ZGUARD    = 8,
  parameter int REPEAT_AT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  input  logic signed [W-1:0] in_z,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_x,
  output logic signed [W-1:0] out_y
);

  localparam int NSHIFT = W + 1;
  localparam int STEPS  = NSHIFT + 1;
  localparam int M      = W + GUARD + 2;
  localparam int SHW    = $clog2(NSHIFT + 1);
  localparam int CW     = $clog2(STEPS + 1);
  localparam int ZW     = W + ZGUARD;
  localparam int LW     = $clog2(STEPS + 3) + 1;

  rot_state_e state_q;
  logic [CW-1:0]    pos_q;
  logic [STEPS-1:0] dir_q, dir_pre;
  logic [M-1:0]     xs_q, xc_q, ys_q, yc_q;
  logic [M-1:0]     xs_n, xc_n, ys_n, yc_n;
  logic signed [W-1:0] rx, ry, ox_q, oy_q;
  logic ovf_x, ovf_y;
  logic signed [ZW-1:0] z_resid;
  logic [SHW-1:0] sh_cur;

  rcordic_dirgen #(.W(W), .ZGUARD(ZGUARD), .STEPS(STEPS), .REP(REPEAT_AT)) u_dirs (
    .angle(in_z), .dir(dir_pre), .resid(z_resid)
  );

  assign sh_cur = (int'(pos_q) > REPEAT_AT) ? SHW'(int'(pos_q) - 1) : SHW'(pos_q);

  rcordic_csa_step #(.M(M), .SHW(SHW)) u_xstep (
    .acc_s(xs_q), .acc_c(xc_q), .op_s(ys_q), .op_c(yc_q),
    .sh(sh_cur), .sub(dir_q[0]), .res_s(xs_n), .res_c(xc_n)
  );

  rcordic_csa_step #(.M(M), .SHW(SHW)) u_ystep (
    .acc_s(ys_q), .acc_c(yc_q), .op_s(xs_q), .op_c(xc_q),
    .sh(sh_cur), .sub(~dir_q[0]), .res_s(ys_n), .res_c(yc_n)
  );

  rcordic_resolve #(.M(M), .W(W), .G(GUARD)) u_xres (
    .sum_v(xs_q), .car_v(xc_q), .value(rx), .spill(ovf_x)
  );

  rcordic_resolve #(.M(M), .W(W), .G(GUARD)) u_yres (
    .sum_v(ys_q), .car_v(yc_q), .value(ry), .spill(ovf_y)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign out_x     = ox_q;
  assign out_y     = oy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      dir_q   <= '0;
      xs_q    <= '0;
      xc_q    <= '0;
      ys_q    <= '0;
      yc_q    <= '0;
      ox_q    <= '0;
      oy_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          xs_q    <= {{2{in_x[W-1]}}, in_x, {GUARD{1'b0}}};
          ys_q    <= {{2{in_y[W-1]}}, in_y, {GUARD{1'b0}}};
          xc_q    <= '0;
          yc_q    <= '0;
          dir_q   <= dir_pre;
          pos_q   <= '0;
          state_q <= ST_ROT;
        end
        ST_ROT: begin
          xs_q  <= xs_n;
          xc_q  <= xc_n;
          ys_q  <= ys_n;
          yc_q  <= yc_n;
          dir_q <= dir_q >> 1;
          pos_q <= pos_q + 1'b1;
          if (int'(pos_q) == STEPS - 1) state_q <= ST_FIN;
        end
        ST_FIN: begin
          ox_q    <= rx;
          oy_q    <= ry;
          state_q <= ST_HOLD;
        end
        default: if (out_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  localparam int HALF_PI_Q = int'(1.5707963267948966 * (2.0 ** (W - 2)));
  localparam logic signed [ZW-1:0] RESID_MAX =
    ZW'(angle_word(NSHIFT - 1, W - 2 + ZGUARD) + 64'sd1);

  logic [LW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                    lat_q <= '0;
    else if (in_valid && in_ready) lat_q <= '0;
    else if (!out_valid && !(&lat_q)) lat_q <= lat_q + 1'b1;
  end

  logic z_in_range;
  assign z_in_range = (int'(in_z) <= HALF_PI_Q) && (int'(in_z) >= -HALF_PI_Q);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == LW'(STEPS + 1)));

  // R8
  resid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && z_in_range) |-> (z_resid <= RESID_MAX && z_resid >= -RESID_MAX));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |-> !(ovf_x || ovf_y));

endmodule

// File: tb/rcordic_rot_test.sv
`timescale 1ns/1ps
module rcordic_rot_test;

  localparam int W     = 16;
  localparam int F     = W - 2;
  localparam int REP   = 3;
  localparam int STEPS = W + 2;
  localparam int HALFQ = 25736;   // round(pi/2 * 2^14)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [W-1:0] in_x = '0, in_y = '0, in_z = '0;
  logic in_ready, out_valid;
  logic signed [W-1:0] out_x, out_y;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  real kgain;

  always #2 clk = ~clk;

  rcordic_rot #(.W(W), .GUARD(8), .ZGUARD(8), .REPEAT_AT(REP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_z(in_z), .out_valid(out_valid),
    .out_ready(out_ready), .out_x(out_x), .out_y(out_y)
  );

  task automatic check_bit(input string tag, input logic got, input logic exp_v);
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp_v);
    end
  endtask

  task automatic check_near(input string tag, input real got, input real exp_v, input real tol);
    real d;
    checks++;
    d = got - exp_v;
    if (d > tol || d < -tol) begin
      errors++;
      $display("FAIL %s got %0f expected %0f", tag, got, exp_v);
    end
  endtask

  // One operation; stall = cycles out_ready is held low, junk = drive busy-time noise.
  task automatic run_op(input int xi, input int yi, input int zi, input int stall,
                        input bit junk, input string tag);
    int j;
    bit busy_ok;
    real th, ex, ey, mag_in, mag_out;
    logic signed [W-1:0] hx, hy;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_x = W'(xi); in_y = W'(yi); in_z = W'(zi);
    @(posedge clk);
    @(negedge clk);
    busy_ok = 1'b1;
    if (junk) begin
      in_x = W'(-xi / 2); in_y = W'(xi / 3); in_z = W'(-zi / 2);
    end else begin
      in_valid = 1'b0;
    end
    j = 0;
    while (!out_valid && j < 100) begin
      if (in_ready) busy_ok = 1'b0;
      @(negedge clk);
      j++;
    end
    in_valid = 1'b0;
    check_bit("R2 in_ready low while busy", !busy_ok, 1'b0);
    check_near("R3 latency", real'(j), real'(STEPS + 1), 0.0);
    th = real'(zi) / (2.0 ** F);
    ex = kgain * (real'(xi) * $cos(th) - real'(yi) * $sin(th));
    ey = kgain * (real'(xi) * $sin(th) + real'(yi) * $cos(th));
    check_near({tag, " x"}, real'(out_x), ex, 2.0);
    check_near({tag, " y"}, real'(out_y), ey, 2.0);
    if (junk) check_near("R9 busy input ignored", real'(out_x), ex, 2.0);
    mag_in  = kgain * $sqrt(real'(xi) * real'(xi) + real'(yi) * real'(yi));
    mag_out = $sqrt(real'(out_x) * real'(out_x) + real'(out_y) * real'(out_y));
    check_near("R7 constant gain", mag_out, mag_in, 3.0);
    hx = out_x; hy = out_y;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check_bit("R4 valid held", out_valid, 1'b1);
      check_bit("R4 data held", (out_x == hx) && (out_y == hy), 1'b1);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check_bit("R4 valid drops after transfer", out_valid, 1'b0);
    check_bit("R4 ready returns", in_ready, 1'b1);
  endtask

  initial begin
    int recip;
    int vals [4];
    kgain = 1.0;
    for (int p = 0; p < STEPS; p++) begin
      int s;
      s = (p > REP) ? p - 1 : p;
      kgain = kgain * $sqrt(1.0 + 2.0 ** (-2 * s));
    end
    recip = int'(2.0 ** F / kgain);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R1 out_valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    check_bit("R1 in_ready after reset", in_ready, 1'b1);

    // R5 / R8: sine and cosine sweep including 0 and both end points
    for (int k = -64; k <= 64; k++)
      run_op(recip, 0, k * HALFQ / 64, k & 1, 1'b0, "R5 sincos");

    // R8 boundaries explicitly
    run_op(recip, 0, 0, 0, 1'b0, "R8 zero angle");
    run_op(recip, 0, HALFQ, 0, 1'b0, "R8 +pi/2");
    run_op(recip, 0, -HALFQ, 0, 1'b0, "R8 -pi/2");

    // R6 / R9: general vectors over an angle grid
    vals[0] = -12288; vals[1] = -4096; vals[2] = 8192; vals[3] = 12288;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int k = -8; k <= 8; k++)
          run_op(vals[a], vals[b], k * HALFQ / 8, (k + 8) % 3,
                 ((a + b + k + 8) % 4) == 0, "R6 rotate");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule